// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small accumulator machine. Its first operand is always the accumulator value. Its second operand is chosen by a four-way selector: memory read data, immediate data from the controller, the value read out of the register file, or the constant one. A 4-bit operation code picks one of sixteen functions. These are add and subtract on a ripple chain of full adders, two's-complement negate, pass-through of either operand, bitwise logic, logical and arithmetic shifts, rotates through the carry, and clear. The result is combinational and is written back by logic outside the block.

Beside the datapath sits a registered flag unit holding Zero, Overflow, Carry and Equal. The flags change on a rising clock edge only when the update enable is high, or when the controller issues a one-hot clear code. Because of this, idle or decode cycles leave them untouched. The rotate operations take their incoming bit from the stored carry flag and return the bit they shift out to it. The width is a parameter with a default of 8.

Top module: `acc_alu`

## Requirements
- R1: The operand select code chooses the second operand B: 00 memory data, 01 immediate data, 10 register data, 11 the constant 1.
- R2: Op 0000 gives A+B modulo 2^W. On an enabled update, C takes the carry out of the MSB and OV is set exactly when A and B share a sign that the result does not (8-bit 82+91 sets OV).
- R3: Op 0001 gives A-B modulo 2^W. On an enabled update, C is set exactly when A < B unsigned (borrow), and OV is set exactly when A and B differ in sign and the result's sign differs from A.
- R4: Ops 0010 (A), 0011 (B), 0100 (AND), 0101 (OR), 0110 (XOR), 1100 (NOT A) and 1101 (zero) give their bitwise results and leave OV and C unchanged.
- R5: Op 0111 gives {0, A[W-1:1]}, 1000 gives {A[W-2:0], 0}, 1010 gives {A[W-1], A[W-1:1]} and 1011 gives {A[W-1], A[W-3:0], 0}. All four leave OV and C unchanged.
- R6: Op 1001 gives -A modulo 2^W. On an enabled update it sets OV exactly when A is the most negative value, and it leaves C unchanged.
- R7: Op 1110 gives {C, A[W-1:1]} using the stored carry. On an enabled update, C takes A[0].
- R8: Op 1111 gives {A[W-2:0], C} using the stored carry. On an enabled update, C takes A[W-1].
- R9: On an enabled update, Z is set exactly when the result is all zeros. This holds for every operation.
- R10: On an enabled update, EQ is set exactly when the accumulator equals the immediate data, whatever the operand select.
- R11: With the update enable low and no valid clear code, all four flags hold across the clock edge.
- R12: Clear code 001 clears Z, 010 clears OV and 100 clears C at the next edge. The clear wins over an update of the same flag in that cycle, and the other flags update normally. Every other nonzero code clears nothing.
- R13: A synchronous active-low reset clears all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the flags |
| acc_i | input | W | Accumulator value, operand A |
| mem_data_i | input | W | Memory read data |
| imm_data_i | input | W | Immediate data from the controller, also the compare value for EQ |
| reg_data_i | input | W | Register file read data |
| opnd_sel_i | input | 2 | Second-operand select code |
| op_i | input | 4 | Operation code |
| flag_clr_i | input | 3 | One-hot flag clear code |
| flag_en_i | input | 1 | Flag update enable |
| result_o | output | W | Combinational result |
| zero_o | output | 1 | Zero flag |
| ovf_o | output | 1 | Signed overflow flag |
| carry_o | output | 1 | Carry / borrow flag |
| equal_o | output | 1 | Equal flag |

## Verification
The bench builds the block at its default width of 8. At that width, random accumulator values drawn with a bias toward 0x00, 0x7F, 0x80 and 0xFF land on the signed and unsigned wrap points often. This covers carry out of 0xFF, borrow, negation of 0x80 and sign changes. The constant-one operand also reaches the all-zero result. Directed cases pin exact values such as 82+91, and chains of rotates carry a bit through the stored carry flag.

// File: rtl/acc_alu_pkg.sv
// Package: shared operation, select and clear encodings for the accumulator ALU.
// Assumes: codes are fixed by the controller that drives the block.
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'b0000,
        OP_SUB   = 4'b0001,
        OP_PASSA = 4'b0010,
        OP_PASSB = 4'b0011,
        OP_AND   = 4'b0100,
        OP_OR    = 4'b0101,
        OP_XOR   = 4'b0110,
        OP_LSR   = 4'b0111,
        OP_LSL   = 4'b1000,
        OP_NEG   = 4'b1001,
        OP_ASR   = 4'b1010,
        OP_ASL   = 4'b1011,
        OP_NOT   = 4'b1100,
        OP_ZERO  = 4'b1101,
        OP_RCR   = 4'b1110,
        OP_RCL   = 4'b1111
    } alu_op_e;

    typedef enum logic [1:0] {
        SEL_MEM  = 2'b00,
        SEL_IMM  = 2'b01,
        SEL_REG  = 2'b10,
        SEL_ONE  = 2'b11
    } opnd_sel_e;

    localparam logic [2:0] CLR_Z  = 3'b001;
    localparam logic [2:0] CLR_OV = 3'b010;
    localparam logic [2:0] CLR_C  = 3'b100;

endpackage

// File: rtl/operand_mux.sv
// Module: operand_mux
// Picks the second ALU operand from memory, immediate, register data or constant one.
// Assumes: select code encodings from acc_alu_pkg; purely combinational.
module operand_mux
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] mem_data,
    input  logic [W-1:0] imm_data,
    input  logic [W-1:0] reg_data,
    input  opnd_sel_e    sel,
    output logic [W-1:0] opnd_b
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // Purpose: four-way operand selection.
    always_comb begin
        unique case (sel)
            SEL_MEM: opnd_b = mem_data;
            SEL_IMM: opnd_b = imm_data;
            SEL_REG: opnd_b = reg_data;
            default: opnd_b = ONE;
        endcase
    end

endmodule

// File: rtl/ripple_adder.sv
// Module: ripple_adder
// W-bit adder built as a chain of full adders, with carry out and signed overflow.
// Assumes: W >= 2; delay grows linearly with W.
module ripple_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);

    for (genvar i = 0; i < W; i++) begin : g_fa
        logic ci;
        logic co;
        if (i == 0) begin : g_first
            assign ci = cin;
        end else begin : g_next
            assign ci = g_fa[i-1].co;
        end
        // full adder cell
        assign sum[i] = x[i] ^ y[i] ^ ci;
        assign co     = (x[i] & y[i]) | (ci & (x[i] ^ y[i]));
    end

    assign cout = g_fa[W-1].co;
    assign ovf  = g_fa[W-1].co ^ g_fa[W-1].ci;

endmodule

// File: rtl/alu_core.sv
// Module: alu_core
// Combinational 16-function datapath on A and B; add, subtract and negate share one adder.
// Assumes: W >= 3 so the arithmetic shift left has a bit field to move; cin is the stored carry flag.
module alu_core
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    input  logic         cin,
    output logic [W-1:0] result,
    output logic         add_cout,
    output logic         add_ovf
);

    logic [W-1:0] add_x;
    logic [W-1:0] add_y;
    logic         add_cin;
    logic [W-1:0] add_sum;

    // Purpose: steer adder inputs for A+B, A+~B+1 and 0+~A+1.
    always_comb begin
        add_x   = a;
        add_y   = b;
        add_cin = 1'b0;
        if (op == OP_SUB) begin
            add_y   = ~b;
            add_cin = 1'b1;
        end else if (op == OP_NEG) begin
            add_x   = '0;
            add_y   = ~a;
            add_cin = 1'b1;
        end
    end

    ripple_adder #(.W(W)) u_adder (
        .x    (add_x),
        .y    (add_y),
        .cin  (add_cin),
        .sum  (add_sum),
        .cout (add_cout),
        .ovf  (add_ovf)
    );

    // Purpose: select the function result.
    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB, OP_NEG: result = add_sum;
            OP_PASSA: result = a;
            OP_PASSB: result = b;
            OP_AND:   result = a & b;
            OP_OR:    result = a | b;
            OP_XOR:   result = a ^ b;
            OP_LSR:   result = {1'b0, a[W-1:1]};
            OP_LSL:   result = {a[W-2:0], 1'b0};
            OP_ASR:   result = {a[W-1], a[W-1:1]};
            OP_ASL:   result = {a[W-1], a[W-3:0], 1'b0};
            OP_NOT:   result = ~a;
            OP_ZERO:  result = '0;
            OP_RCR:   result = {cin, a[W-1:1]};
            default:  result = {a[W-2:0], cin};
        endcase
    end

endmodule

// File: rtl/flag_unit.sv
// Module: flag_unit
// Registered Z, OV, C and EQ flags with update enable and one-hot clear.
// Assumes: clear codes other than the three one-hot values are no-ops; clear beats update.
module flag_unit
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [2:0]   clr,
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] imm,
    input  logic [W-1:0] result,
    input  logic         add_cout,
    input  logic         add_ovf,
    output logic         z_q,
    output logic         ov_q,
    output logic         c_q,
    output logic         eq_q
);

    logic z_d, ov_d, c_d, eq_d;

    // Purpose: next-state of each flag from operation class, then apply clear.
    always_comb begin
        z_d  = z_q;
        ov_d = ov_q;
        c_d  = c_q;
        eq_d = eq_q;
        if (en) begin
            z_d  = (result == '0);
            eq_d = (a == imm);
            case (op)
                OP_ADD: begin c_d = add_cout;  ov_d = add_ovf; end
                OP_SUB: begin c_d = ~add_cout; ov_d = add_ovf; end
                OP_NEG: ov_d = add_ovf;
                OP_RCR: c_d = a[0];
                OP_RCL: c_d = a[W-1];
                default: ;
            endcase
        end
        case (clr)
            CLR_Z:   z_d  = 1'b0;
            CLR_OV:  ov_d = 1'b0;
            CLR_C:   c_d  = 1'b0;
            default: ;
        endcase
    end

    // Purpose: flag registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z_q  <= 1'b0;
            ov_q <= 1'b0;
            c_q  <= 1'b0;
            eq_q <= 1'b0;
        end else begin
            z_q  <= z_d;
            ov_q <= ov_d;
            c_q  <= c_d;
            eq_q <= eq_d;
        end
    end

    // R12
    zero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr == CLR_Z |=> !z_q);
    // R12
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr == CLR_OV |=> !ov_q);
    // R12
    carry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr == CLR_C |=> !c_q);
    // R11
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && clr != CLR_Z && clr != CLR_OV && clr != CLR_C)
        |=> $stable({z_q, ov_q, c_q, eq_q}));
    // R7
    rcr_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OP_RCR && clr != CLR_C) |=> c_q == $past(a[0]));
    // R8
    rcl_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OP_RCL && clr != CLR_C) |=> c_q == $past(a[W-1]));

endmodule

// File: rtl/acc_alu.sv
// Module: acc_alu (top)
// Accumulator ALU: operand select, 16-function datapath and registered status flags.
// Assumes: W >= 3; the accumulator register and write-back live outside this block.
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] mem_data_i,
    input  logic [W-1:0] imm_data_i,
    input  logic [W-1:0] reg_data_i,
    input  logic [1:0]   opnd_sel_i,
    input  logic [3:0]   op_i,
    input  logic [2:0]   flag_clr_i,
    input  logic         flag_en_i,
    output logic [W-1:0] result_o,
    output logic         zero_o,
    output logic         ovf_o,
    output logic         carry_o,
    output logic         equal_o
);

    logic [W-1:0] opnd_b;
    logic         add_cout;
    logic         add_ovf;
    alu_op_e      op;

    assign op = alu_op_e'(op_i);

    operand_mux #(.W(W)) u_mux (
        .mem_data (mem_data_i),
        .imm_data (imm_data_i),
        .reg_data (reg_data_i),
        .sel      (opnd_sel_e'(opnd_sel_i)),
        .opnd_b   (opnd_b)
    );

    alu_core #(.W(W)) u_core (
        .a        (acc_i),
        .b        (opnd_b),
        .op       (op),
        .cin      (carry_o),
        .result   (result_o),
        .add_cout (add_cout),
        .add_ovf  (add_ovf)
    );

    flag_unit #(.W(W)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (flag_en_i),
        .clr      (flag_clr_i),
        .op       (op),
        .a        (acc_i),
        .imm      (imm_data_i),
        .result   (result_o),
        .add_cout (add_cout),
        .add_ovf  (add_ovf),
        .z_q      (zero_o),
        .ov_q     (ovf_o),
        .c_q      (carry_o),
        .eq_q     (equal_o)
    );

    // R2
    add_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_ADD |-> result_o == W'(acc_i + opnd_b));
    // R3
    sub_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_SUB |-> W'(result_o + opnd_b) == acc_i);
    // R13
    reset_flags_chk: assert property (@(posedge clk)
        !rst_n |=> {zero_o, ovf_o, carry_o, equal_o} == 4'b0000);

endmodule

// File: tb/tb_acc_alu.sv
module tb_acc_alu;

    localparam int W     = 8;
    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] acc_i = '0, mem_data_i = '0, imm_data_i = '0, reg_data_i = '0;
    logic [1:0]   opnd_sel_i = '0;
    logic [3:0]   op_i = '0;
    logic [2:0]   flag_clr_i = '0;
    logic         flag_en_i = 1'b0;
    logic [W-1:0] result_o;
    logic         zero_o, ovf_o, carry_o, equal_o;

    int checks = 0;
    int errors = 0;
    logic mz = 0, mov = 0, mc = 0, meq = 0;

    always #(CLK_P/2) clk = ~clk;

    acc_alu #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .acc_i(acc_i), .mem_data_i(mem_data_i),
        .imm_data_i(imm_data_i), .reg_data_i(reg_data_i), .opnd_sel_i(opnd_sel_i),
        .op_i(op_i), .flag_clr_i(flag_clr_i), .flag_en_i(flag_en_i),
        .result_o(result_o), .zero_o(zero_o), .ovf_o(ovf_o), .carry_o(carry_o),
        .equal_o(equal_o)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string op_tag(input logic [3:0] op);
        case (op)
            4'h0: return "R2";
            4'h1: return "R3";
            4'h9: return "R6";
            4'hE: return "R7";
            4'hF: return "R8";
            4'h7, 4'h8, 4'hA, 4'hB: return "R5";
            default: return "R4";
        endcase
    endfunction

    function automatic logic [W-1:0] ref_res(input logic [3:0] op, input logic [W-1:0] a,
                                             input logic [W-1:0] b, input logic c);
        case (op)
            4'h0: return a + b;
            4'h1: return a - b;
            4'h2: return a;
            4'h3: return b;
            4'h4: return a & b;
            4'h5: return a | b;
            4'h6: return a ^ b;
            4'h7: return a >> 1;
            4'h8: return a << 1;
            4'h9: return -a;
            4'hA: return $signed(a) >>> 1;
            4'hB: return {a[W-1], a[W-3:0], 1'b0};
            4'hC: return ~a;
            4'hD: return '0;
            4'hE: return {c, a[W-1:1]};
            default: return {a[W-2:0], c};
        endcase
    endfunction

    task automatic step(input logic [3:0] op, input logic [1:0] sel, input logic [W-1:0] a,
                        input logic [W-1:0] m, input logic [W-1:0] k, input logic [W-1:0] r,
                        input logic en, input logic [2:0] clr, input string ftag);
        logic [W-1:0] b, er;
        logic nz, nov, nc, neq;
        logic [W:0] wide;
        @(negedge clk);
        op_i = op; opnd_sel_i = sel; acc_i = a; mem_data_i = m; imm_data_i = k;
        reg_data_i = r; flag_en_i = en; flag_clr_i = clr;
        #1;
        case (sel)
            2'b00: b = m;
            2'b01: b = k;
            2'b10: b = r;
            default: b = 1;
        endcase
        er = ref_res(op, a, b, mc);
        chk(op_tag(op), result_o, er);
        nz = mz; nov = mov; nc = mc; neq = meq;
        if (en) begin
            nz = (er == 0);
            neq = (a == k);
            case (op)
                4'h0: begin wide = a + b; nc = wide[W];
                            nov = (a[W-1] == b[W-1]) && (er[W-1] != a[W-1]); end
                4'h1: begin nc = (a < b);
                            nov = (a[W-1] != b[W-1]) && (er[W-1] != a[W-1]); end
                4'h9: nov = (a == {1'b1, {(W-1){1'b0}}});
                4'hE: nc = a[0];
                4'hF: nc = a[W-1];
                default: ;
            endcase
        end
        if (clr == 3'b001) nz = 0;
        if (clr == 3'b010) nov = 0;
        if (clr == 3'b100) nc = 0;
        @(posedge clk); #1;
        chk(ftag.len() != 0 ? ftag :
            (clr == 3'b001 || clr == 3'b010 || clr == 3'b100) ? "R12" :
            (!en ? "R11" : op_tag(op)),
            W'({zero_o, ovf_o, carry_o, equal_o}), W'({nz, nov, nc, neq}));
        mz = nz; mov = nov; mc = nc; meq = neq;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        @(posedge clk); #1;
        chk("R13", W'({zero_o, ovf_o, carry_o, equal_o}), '0);
        mz = 0; mov = 0; mc = 0; meq = 0;
        @(negedge clk); rst_n = 1;
    endtask

    function automatic logic [W-1:0] pick();
        case ($urandom_range(0, 5))
            0: return '0;
            1: return {1'b0, {(W-1){1'b1}}};
            2: return {1'b1, {(W-1){1'b0}}};
            3: return '1;
            default: return W'($urandom);
        endcase
    endfunction

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        do_reset();
        // R1: each select code routed through pass-B
        step(4'h3, 2'b00, 8'h00, 8'h11, 8'h22, 8'h33, 1, 3'b000, "R1");
        chk("R1", result_o, 8'h11);
        step(4'h3, 2'b01, 8'h00, 8'h11, 8'h22, 8'h33, 1, 3'b000, "R1");
        step(4'h3, 2'b10, 8'h00, 8'h11, 8'h22, 8'h33, 1, 3'b000, "R1");
        step(4'h3, 2'b11, 8'h00, 8'h11, 8'h22, 8'h33, 1, 3'b000, "R1");
        // R2: 82 + 91 overflows signed
        step(4'h0, 2'b01, 8'd82, 8'h00, 8'd91, 8'h00, 1, 3'b000, "R2");
        chk("R2", W'(ovf_o), 1);
        // R9: 0xFF + constant one wraps to zero with carry
        step(4'h0, 2'b11, 8'hFF, 8'h00, 8'h00, 8'h00, 1, 3'b000, "R9");
        chk("R9", W'({zero_o, carry_o}), 2'b11);
        // R7: rotate right brings carry into MSB
        step(4'hE, 2'b00, 8'h02, 8'h00, 8'h00, 8'h00, 1, 3'b000, "R7");
        chk("R7", W'(carry_o), 0);
        // R8: rotate left sends MSB to carry
        step(4'hF, 2'b00, 8'h80, 8'h00, 8'h00, 8'h00, 1, 3'b000, "R8");
        chk("R8", W'(carry_o), 1);
        // R3: 3 - 5 borrows
        step(4'h1, 2'b10, 8'd3, 8'h00, 8'h00, 8'd5, 1, 3'b000, "R3");
        chk("R3", result_o, 8'hFE);
        // R6: negate most negative value
        step(4'h9, 2'b00, 8'h80, 8'h00, 8'h00, 8'h00, 1, 3'b000, "R6");
        chk("R6", W'(ovf_o), 1);
        // R10: equal compare with memory selected
        step(4'h2, 2'b00, 8'h5A, 8'h01, 8'h5A, 8'h00, 1, 3'b000, "R10");
        chk("R10", W'(equal_o), 1);
        // R11: disabled update holds flags
        step(4'h1, 2'b01, 8'h00, 8'h00, 8'h01, 8'h00, 0, 3'b000, "R11");
        // R12: clear Z beats a zero result; invalid code clears nothing
        step(4'hD, 2'b00, 8'h00, 8'h00, 8'h00, 8'h00, 1, 3'b001, "R12");
        chk("R12", W'(zero_o), 0);
        step(4'h0, 2'b11, 8'hFF, 8'h00, 8'h00, 8'h00, 1, 3'b000, "R12");
        step(4'h2, 2'b00, 8'h00, 8'h00, 8'h00, 8'h00, 0, 3'b011, "R12");
        step(4'h2, 2'b00, 8'h00, 8'h00, 8'h00, 8'h00, 0, 3'b100, "R12");
        // R13: reset again after flags were set
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] clr;
            clr = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b000;
            step(4'($urandom), 2'($urandom), pick(), pick(), pick(), pick(),
                 ($urandom_range(0, 4) != 0), clr, "");
        end
        finish_run();
    end

endmodule